// File: doc/BRIEF.md
# Raster Position and Interrupt Unit

This block tracks the beam position of a raster video controller. It keeps a cycle-within-line counter and a line-within-frame counter. A two-bit geometry select chooses between three frame shapes. The line counter is compared with a programmable 9-bit line number; when the counter arrives at that value, a raster flag is set. A light-pen strobe captures the current beam position once per frame and sets a second flag.

Flags, a four-bit enable mask and a summary bit combine into one active-high interrupt line. Everything is reached through a byte-wide register bus that decodes 64 locations. Addresses beyond that range read as zero, and writes to them change nothing.

The line counter steps on the cycle where the cycle counter wraps to zero. The last line of a frame is different: at that wrap it does not step. Instead it spends one blank cycle and then jumps to line 0 with the cycle counter at 1. So line 0 is one cycle shorter than the other lines, and a whole frame is exactly lines × cycles clock cycles.

Top module: `raster_irq_unit`

## Requirements
- R1: `model_sel` picks the frame shape: 0 gives 262 lines of 64 cycles, 1 gives 263 lines of 65 cycles, and 2 or 3 give 312 lines of 63 cycles.
- R2: The cycle counter counts 0 up to cycles−1 and wraps to 0. After synchronous reset the cycle counter is 0, the line counter is lines−1, every register is 0 and `irq_o` is low.
- R3: When the cycle counter wraps on the last line, the line counter holds for one blank cycle. On the next edge it becomes 0 and the cycle counter becomes 1. The same compare value recurs every lines × cycles clock cycles.
- R4: Flag bit 0 (raster) is set on the edge where the line counter takes the compare value, and this includes line 0. The compare value's bits 7..0 are written at 0x12, and its bit 8 is bit 7 of a write to 0x11.
- R5: A read of 0x12 returns line bits 7..0. A read of 0x11 returns line bit 8 in bit 7, with the stored control bits 6..0 below it.
- R6: A read of 0x19 returns {summary, 3'b000, flags[3:0]}. Writing 1 to any of bits 3..0 clears that flag. The summary bit and `irq_o` drop only when no flag is left.
- R7: 0x1A holds a 4-bit mask and reads back as {4'hF, mask}. A mask write that overlaps a set flag raises the summary. A mask write that overlaps no set flag clears every flag and the summary.
- R8: The summary bit and `irq_o` go high when a flag is set under a set mask bit, and they stay high until R6 or R7 drops them. A flag whose mask bit is clear does not raise `irq_o`.
- R9: `pen_in`, when armed, latches (cycle×4) mod 256 at 0x13 and line bits 7..0 at 0x14, and sets flag bit 3. Further strobes are ignored until the blank cycle re-arms the latch.
- R10: Addresses 0x2F–0x3F read 0xFF. Addresses of 0x40 and above read 0x00 and ignore writes. Other undecoded addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| model_sel | input | 2 | Frame geometry select |
| bus_addr | input | 7 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pen_in | input | 1 | Light-pen strobe |
| line_cnt | output | 9 | Current line |
| cyc_cnt | output | 7 | Current cycle within the line |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
On every cycle, the assertions check these properties:
- the cycle counter steps by one and wraps at the model's limit;
- the line counter never passes the last line;
- the blank cycle lands on line 0 at cycle 1;
- a compare hit always leaves the raster flag set;
- `irq_o` never stands without a flag;
- the pen latch fires at most once between blank cycles.

Only the bench scenarios can show the rest:
- the full frame period and the exact cycle of the first hit for each geometry;
- the decoded read values;
- the write-one-to-clear rule together with summary retention;
- the side effect of a non-overlapping mask write;
- that a second strobe leaves the pen coordinates untouched.

// File: rtl/raster_pkg.sv
package raster_pkg;
    localparam int LINE_W  = 9;
    localparam int CYC_W   = 7;
    localparam int DATA_W  = 8;
    localparam int NFLAG   = 4;

    localparam logic [5:0] ADR_CTRL    = 6'h11;
    localparam logic [5:0] ADR_CMP     = 6'h12;
    localparam logic [5:0] ADR_PENX    = 6'h13;
    localparam logic [5:0] ADR_PENY    = 6'h14;
    localparam logic [5:0] ADR_FLAG    = 6'h19;
    localparam logic [5:0] ADR_MASK    = 6'h1A;
    localparam logic [5:0] ADR_OPEN_LO = 6'h2F;

    localparam int FLG_RASTER = 0;
    localparam int FLG_PEN    = 3;

    typedef enum logic {PH_RUN, PH_BLANK} phase_e;
    typedef enum logic {IRQ_IDLE, IRQ_ACTIVE} irq_state_e;

    function automatic logic [LINE_W-1:0] geo_lines(input logic [1:0] sel);
        unique case (sel)
            2'd0:    geo_lines = 9'd262;
            2'd1:    geo_lines = 9'd263;
            default: geo_lines = 9'd312;
        endcase
    endfunction

    function automatic logic [CYC_W-1:0] geo_cycles(input logic [1:0] sel);
        unique case (sel)
            2'd0:    geo_cycles = 7'd64;
            2'd1:    geo_cycles = 7'd65;
            default: geo_cycles = 7'd63;
        endcase
    endfunction
endpackage

// File: rtl/raster_timing.sv
module raster_timing
    import raster_pkg::*;
#(
    parameter int LW = LINE_W,
    parameter int CW = CYC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    model_sel,
    input  logic [LW-1:0] cmp_val,
    output logic [CW-1:0] cyc,
    output logic [LW-1:0] line,
    output logic          frame_start,
    output logic          line_hit
);
    phase_e        phase_q, phase_d;
    logic [LW-1:0] last_line, line_d;
    logic [CW-1:0] last_cyc, cyc_d;
    logic          wrap, at_last, line_step;

    assign last_line = LW'(geo_lines(model_sel)) - LW'(1);
    assign last_cyc  = CW'(geo_cycles(model_sel)) - CW'(1);
    assign wrap      = (cyc == last_cyc);
    assign at_last   = (line >= last_line);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RUN;
            cyc     <= '0;
            line    <= last_line;
        end else begin
            phase_q <= phase_d;
            cyc     <= cyc_d;
            line    <= line_d;
        end
    end

    // transitions: RUN_TO_BLANK on last-line wrap, BLANK_TO_RUN always
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_RUN:   if (wrap && at_last) phase_d = PH_BLANK;
            PH_BLANK: phase_d = PH_RUN;
        endcase
    end

    // outputs
    always_comb begin
        cyc_d       = wrap ? '0 : cyc + CW'(1);
        line_d      = line;
        frame_start = 1'b0;
        line_step   = 1'b0;
        unique case (phase_q)
            PH_RUN: begin
                if (wrap && !at_last) begin
                    line_d    = line + LW'(1);
                    line_step = 1'b1;
                end
            end
            PH_BLANK: begin
                line_d      = '0;
                frame_start = 1'b1;
                line_step   = 1'b1;
            end
        endcase
        line_hit = line_step && (line_d == cmp_val);
    end
endmodule

// File: rtl/pen_latch.sv
module pen_latch
    import raster_pkg::*;
#(
    parameter int LW = LINE_W,
    parameter int CW = CYC_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pen_in,
    input  logic          frame_start,
    input  logic [CW-1:0] cyc,
    input  logic [LW-1:0] line,
    output logic [DW-1:0] pen_x,
    output logic [DW-1:0] pen_y,
    output logic          pen_ev
);
    logic          armed;
    logic [CW+1:0] x_scaled;

    assign x_scaled = {cyc, 2'b00};
    assign pen_ev   = pen_in && armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
            pen_x <= '0;
            pen_y <= '0;
        end else begin
            if (pen_ev) begin
                pen_x <= x_scaled[DW-1:0];
                pen_y <= line[DW-1:0];
            end
            if (frame_start)  armed <= 1'b1;
            else if (pen_ev)  armed <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import raster_pkg::*;
#(
    parameter int NF = NFLAG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_flag,
    input  logic          wr_mask,
    input  logic [NF-1:0] wr_bits,
    input  logic [NF-1:0] set_bits,
    output logic [NF-1:0] flags,
    output logic [NF-1:0] mask,
    output logic          irq
);
    irq_state_e    st_q, st_d;
    logic [NF-1:0] fl_w, flags_d, mask_d;
    logic          drop, clr_all;

    always_comb begin
        fl_w    = wr_flag ? (flags & ~wr_bits) : flags;
        mask_d  = wr_mask ? wr_bits : mask;
        clr_all = wr_mask && ((wr_bits & fl_w) == '0);
        flags_d = (clr_all ? '0 : fl_w) | set_bits;
        drop    = (wr_flag && (fl_w == '0)) || clr_all;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= IRQ_IDLE;
            flags <= '0;
            mask  <= '0;
        end else begin
            st_q  <= st_d;
            flags <= flags_d;
            mask  <= mask_d;
        end
    end

    // transitions: IDLE_TO_ACTIVE on enabled flag, ACTIVE_TO_IDLE on drop
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_IDLE:   if ((flags_d & mask_d) != '0) st_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (drop && ((set_bits & mask_d) == '0)) st_d = IRQ_IDLE;
        endcase
    end

    // output
    always_comb irq = (st_q == IRQ_ACTIVE);
endmodule

// File: rtl/raster_irq_unit.sv
module raster_irq_unit
    import raster_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          model_sel,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                pen_in,
    output logic [LINE_W-1:0]   line_cnt,
    output logic [CYC_W-1:0]    cyc_cnt,
    output logic                irq_o
);
    logic               in_space;
    logic [5:0]         lo;
    logic [DATA_W-1:0]  ctrl_q, pen_x, pen_y;
    logic [LINE_W-1:0]  cmp_q;
    logic               frame_start, line_hit, pen_ev;
    logic [NFLAG-1:0]   flags, mask, set_bits;
    logic               wr_ok;

    generate
        if (ADDR_W > 6) begin : g_wide
            assign in_space = ~|bus_addr[ADDR_W-1:6];
        end else begin : g_narrow
            assign in_space = 1'b1;
        end
    endgenerate

    assign lo    = bus_addr[5:0];
    assign wr_ok = bus_wr && in_space;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
        end else if (wr_ok) begin
            if (lo == ADR_CTRL) begin
                ctrl_q           <= bus_wdata;
                cmp_q[LINE_W-1]  <= bus_wdata[DATA_W-1];
            end
            if (lo == ADR_CMP) cmp_q[DATA_W-1:0] <= bus_wdata;
        end
    end

    raster_timing u_tim (
        .clk(clk), .rst_n(rst_n), .model_sel(model_sel), .cmp_val(cmp_q),
        .cyc(cyc_cnt), .line(line_cnt), .frame_start(frame_start), .line_hit(line_hit)
    );

    pen_latch u_pen (
        .clk(clk), .rst_n(rst_n), .pen_in(pen_in), .frame_start(frame_start),
        .cyc(cyc_cnt), .line(line_cnt), .pen_x(pen_x), .pen_y(pen_y), .pen_ev(pen_ev)
    );

    always_comb begin
        set_bits             = '0;
        set_bits[FLG_RASTER] = line_hit;
        set_bits[FLG_PEN]    = pen_ev;
    end

    irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n),
        .wr_flag(wr_ok && (lo == ADR_FLAG)), .wr_mask(wr_ok && (lo == ADR_MASK)),
        .wr_bits(bus_wdata[NFLAG-1:0]), .set_bits(set_bits),
        .flags(flags), .mask(mask), .irq(irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (in_space) begin
            if (lo >= ADR_OPEN_LO) bus_rdata = '1;
            else begin
                case (lo)
                    ADR_CTRL: bus_rdata = {line_cnt[LINE_W-1], ctrl_q[DATA_W-2:0]};
                    ADR_CMP:  bus_rdata = line_cnt[DATA_W-1:0];
                    ADR_PENX: bus_rdata = pen_x;
                    ADR_PENY: bus_rdata = pen_y;
                    ADR_FLAG: bus_rdata = {irq_o, 3'b000, flags};
                    ADR_MASK: bus_rdata = {4'hF, mask};
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/raster_irq_unit_chk.sv
module raster_irq_unit_chk
    import raster_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        model_sel,
    input logic [LINE_W-1:0] line_cnt,
    input logic [CYC_W-1:0]  cyc_cnt,
    input logic              frame_start,
    input logic              line_hit,
    input logic              pen_ev,
    input logic [NFLAG-1:0]  flags,
    input logic              irq_o
);
    logic [CYC_W-1:0]  last_cyc;
    logic [LINE_W-1:0] last_line;
    logic [1:0]        pen_cnt;

    assign last_cyc  = geo_cycles(model_sel) - 7'd1;
    assign last_line = geo_lines(model_sel) - 9'd1;

    always_ff @(posedge clk) begin
        if (!rst_n)                         pen_cnt <= '0;
        else if (frame_start)               pen_cnt <= '0;
        else if (pen_ev && pen_cnt != 2'd3) pen_cnt <= pen_cnt + 2'd1;
    end

    a_r2_cyc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_cnt == last_cyc) |=> (cyc_cnt == '0));
    a_r2_cyc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_cnt != last_cyc) |=> (cyc_cnt == $past(cyc_cnt) + 7'd1));
    a_r3_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
        line_cnt <= last_line);
    a_r3_blank_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (line_cnt == '0 && cyc_cnt == 7'd1));
    a_r4_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        line_hit |=> flags[FLG_RASTER]);
    a_r8_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags != '0));
    a_r9_pen_once: assert property (@(posedge clk) disable iff (!rst_n)
        pen_cnt <= 2'd1);
endmodule

bind raster_irq_unit raster_irq_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .model_sel(model_sel), .line_cnt(line_cnt),
    .cyc_cnt(cyc_cnt), .frame_start(frame_start), .line_hit(line_hit),
    .pen_ev(pen_ev), .flags(flags), .irq_o(irq_o)
);

// File: tb/raster_irq_unit_test.sv
`timescale 1ns/1ps
module raster_irq_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] model_sel = 2'd0;
    logic [6:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pen_in = 1'b0;
    logic [8:0] line_cnt;
    logic [6:0] cyc_cnt;
    logic       irq_o;

    int nchk = 0, nfail = 0, ncyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) ncyc++;

    raster_irq_unit uut (.*);

    // {model, compare line}
    localparam logic [10:0] VEC [0:3] = '{
        {2'd0, 9'd0}, {2'd1, 9'd262}, {2'd2, 9'd311}, {2'd2, 9'd5}
    };

    function automatic int exp_lines(input logic [1:0] m);
        return (m == 2'd0) ? 262 : (m == 2'd1) ? 263 : 312;
    endfunction
    function automatic int exp_cycles(input logic [1:0] m);
        return (m == 2'd0) ? 64 : (m == 2'd1) ? 65 : 63;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; model_sel = m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_irq();
        @(negedge clk);
        while (!irq_o) @(negedge clk);
    endtask

    task automatic wait_pos(input int ln, input int cy);
        @(negedge clk);
        while (!(line_cnt == 9'(ln) && cyc_cnt == 7'(cy))) @(negedge clk);
    endtask

    task automatic pulse_pen();
        pen_in = 1'b1;
        @(negedge clk);
        pen_in = 1'b0;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int t1, t2;

        // vector walk: first hit position and frame period per geometry
        for (int i = 0; i < 4; i++) begin
            logic [1:0] m;
            logic [8:0] c;
            m = VEC[i][10:9];
            c = VEC[i][8:0];
            do_reset(m);
            wr(7'h1A, 8'h01);
            wr(7'h12, c[7:0]);
            wr(7'h11, {c[8], 7'h00});
            wait_irq();
            t1 = ncyc;
            chk("R4 line at hit", line_cnt, c);
            chk("R3 cycle at hit", cyc_cnt, (c == 0) ? 1 : 0);
            rd(7'h12, d); chk("R5 line low read", d, c[7:0]);
            rd(7'h11, d); chk("R5 line bit8 read", d[7], c[8]);
            rd(7'h19, d); chk("R8 flag+summary", d, 8'h81);
            wr(7'h19, 8'h01);
            chk("R6 irq dropped", irq_o, 0);
            rd(7'h19, d); chk("R6 flags cleared", d, 8'h00);
            wait_irq();
            t2 = ncyc;
            chk("R1 R3 frame period", t2 - t1, exp_lines(m) * exp_cycles(m));
        end

        // model 3 aliases the 312-line geometry
        do_reset(2'd3);
        chk("R1 model3 reset line", line_cnt, 311);

        // reset state
        do_reset(2'd0);
        chk("R2 reset irq", irq_o, 0);
        chk("R2 reset line", line_cnt, 261);
        chk("R2 reset cycle", cyc_cnt, 0);
        rd(7'h19, d); chk("R2 reset flags", d, 8'h00);
        rd(7'h1A, d); chk("R7 reset mask read", d, 8'hF0);
        rd(7'h13, d); chk("R2 reset pen x", d, 8'h00);
        rd(7'h14, d); chk("R2 reset pen y", d, 8'h00);
        rd(7'h11, d); chk("R5 ctrl read bit8 set", d, 8'h80);
        rd(7'h12, d); chk("R5 line low at reset", d, 8'h05);

        // address space edges
        rd(7'h2F, d); chk("R10 open low", d, 8'hFF);
        rd(7'h3F, d); chk("R10 open high", d, 8'hFF);
        rd(7'h40, d); chk("R10 out of space read", d, 8'h00);
        rd(7'h00, d); chk("R10 undecoded read", d, 8'h00);
        wr(7'h5A, 8'h0F);
        rd(7'h1A, d); chk("R10 out of space write ignored", d, 8'hF0);
        wr(7'h11, 8'h3B);
        rd(7'h11, d); chk("R5 ctrl bits readback", d, 8'hBB);
        wr(7'h11, 8'h00);

        // masked raster flag at line 0, then mask write raises irq
        wait_pos(0, 1);
        chk("R8 masked flag no irq", irq_o, 0);
        rd(7'h19, d); chk("R4 line0 flag", d, 8'h01);
        wr(7'h1A, 8'h01);
        chk("R7 mask overlap raises", irq_o, 1);

        // light pen
        wait_pos(3, 20);
        pulse_pen();
        rd(7'h13, d); chk("R9 pen x", d, 8'd80);
        rd(7'h14, d); chk("R9 pen y", d, 8'd3);
        rd(7'h19, d); chk("R9 pen flag", d, 8'h89);
        wr(7'h19, 8'h08);
        chk("R6 summary held", irq_o, 1);
        rd(7'h19, d); chk("R6 partial clear", d, 8'h81);
        wait_pos(10, 7);
        pulse_pen();
        rd(7'h13, d); chk("R9 second strobe x", d, 8'd80);
        rd(7'h14, d); chk("R9 second strobe y", d, 8'd3);
        rd(7'h19, d); chk("R9 no second flag", d, 8'h81);
        wr(7'h1A, 8'h02);
        chk("R7 no overlap drops irq", irq_o, 0);
        rd(7'h19, d); chk("R7 no overlap clears flags", d, 8'h00);
        wr(7'h12, 8'hFF);
        wr(7'h11, 8'h80);

        // re-armed after the frame wraps
        wait_pos(0, 1);
        wait_pos(200, 63);
        pulse_pen();
        rd(7'h13, d); chk("R9 rearmed x", d, 8'hFC);
        rd(7'h14, d); chk("R9 rearmed y", d, 8'hC8);
        rd(7'h19, d); chk("R9 rearmed flag", d, 8'h08);
        chk("R8 pen masked no irq", irq_o, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule